// File: doc/BRIEF.md
# Four-Channel Periodic Down-Counter Timer

This block gives a chip four independent periodic timers that share one time-base. Each channel has a 16-bit down-counter and a 16-bit reload value. On every cycle where the shared `tick` input is high and the channel is enabled, the counter drops by one. A tick that finds the counter at zero raises the channel's time-out flag and refills the counter from its reload value, so the period is reload value plus one ticks. A prescaler outside the block supplies the tick.

Software sees the block through a small synchronous register bus. Every access is a full word. Software writes the reload values, the enable and interrupt-enable masks, and a force-load strobe mask. It reads the live counts and clears flags by writing ones. A new reload value does not touch the running count: it is used at the next terminal count, or at once if software forces a load. Each channel drives an interrupt output that is high while its flag and its interrupt enable are both set.

Word addresses: 0 enable mask (bit n = channel n), 1 interrupt-enable mask, 2 flags (read; write one to clear), 3 force-load strobe (write ones; reads as 0), 4+n reload value of channel n, 8+n live count of channel n (read only). Reads are registered: `bus_rdata` and `bus_rvalid` are valid in the cycle after `bus_rd`. Unmapped reads return 0.

Top module: `pit_timer`

## Requirements
- R1: After synchronous reset, every count, reload value, enable bit, interrupt-enable bit and flag reads 0, and `irq` is 0.
- R2: A channel's count decreases by exactly one on each clock where its enable bit (address 0) is set, `tick` is high and the count is non-zero. Without tick or enable the count holds.
- R3: A tick on an enabled channel whose count is 0 loads the reload value into the count and sets the channel's flag (address 2, bit n).
- R4: Writing a reload value (address 4+n) leaves the running count unchanged. The new value is the one loaded at the next terminal count.
- R5: Writing a one to bit n of address 3 copies channel n's reload value into its count on that clock and does not set its flag. This takes priority over a tick in the same cycle.
- R6: Writes to the count addresses (8+n) have no effect on the count.
- R7: Writing a one to a flag bit clears it, and a zero bit leaves it alone. When a clear and a new time-out happen in the same cycle, the flag stays set.
- R8: `irq[n]` is high exactly when flag n and interrupt-enable bit n (address 1) are both set.
- R9: Channels are independent. Ticks, reloads and flags on one channel leave the counts and flags of the others untouched.
- R10: A reload register reads back the full 16-bit word last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared time-base pulse, one decrement per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | CW (16) | Write data |
| bus_rdata | output | CW (16) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after bus_rd |
| irq | output | NCH (4) | Per-channel interrupt requests |

## Verification
A wrong count shows up the next time software reads the count register. When the counter is left running, it also shows up as a time-out flag that rises one or more ticks early or late. A lost or stuck flag appears on `irq` in the very cycle after the faulty edge, provided the interrupt enable is set. A bad priority between force-load, tick and flag clear leaves a count that is off by one, or a flag that is wrongly cleared. The bench provokes each of these races on purpose and reads the results back straight away.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DEF_NCH = 4;
    localparam int DEF_CW  = 16;

    // fixed control word addresses; per-channel blocks follow
    localparam int A_EN    = 0;
    localparam int A_IE    = 1;
    localparam int A_FLG   = 2;
    localparam int A_FRC   = 3;
    localparam int LD_BASE = 4;

    typedef enum logic [2:0] {
        K_NONE,
        K_EN,
        K_IE,
        K_FLG,
        K_FRC,
        K_LD,
        K_CNT
    } reg_kind_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } bus_op_t;

    function automatic int cnt_base(input int nch);
        return LD_BASE + nch;
    endfunction

    function automatic int addr_width(input int nch);
        return $clog2(LD_BASE + 2 * nch);
    endfunction

    function automatic reg_kind_e kind_of(input int a, input int nch);
        if (a == A_EN)                               return K_EN;
        if (a == A_IE)                               return K_IE;
        if (a == A_FLG)                              return K_FLG;
        if (a == A_FRC)                              return K_FRC;
        if (a >= LD_BASE && a < cnt_base(nch))       return K_LD;
        if (a >= cnt_base(nch) && a < cnt_base(nch) + nch) return K_CNT;
        return K_NONE;
    endfunction

endpackage

// File: rtl/pit_chan.sv
module pit_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          frc,
    input  logic          clr,
    input  logic [CW-1:0] ld,
    output logic [CW-1:0] cnt_q,
    output logic          flag_q
);

    logic step;
    logic expire;

    always_comb begin
        step   = en && tick && !frc;
        expire = step && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (frc)
                cnt_q <= ld;
            else if (expire)
                cnt_q <= ld;
            else if (step)
                cnt_q <= cnt_q - CW'(1);
            // new time-out beats a same-cycle clear
            flag_q <= expire || (flag_q && !clr);
        end
    end

endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int NCH = DEF_NCH,
    parameter int CW  = DEF_CW,
    parameter int AW  = addr_width(NCH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [AW-1:0]          bus_addr,
    input  logic [CW-1:0]          bus_wdata,
    input  logic [NCH-1:0][CW-1:0] cnt_vec,
    input  logic [NCH-1:0]         flag_vec,
    output logic [NCH-1:0]         en_q,
    output logic [NCH-1:0]         ie_q,
    output logic [NCH-1:0][CW-1:0] ld_vec,
    output logic [NCH-1:0]         frc_vec,
    output logic [NCH-1:0]         clr_vec,
    output logic [CW-1:0]          rdata_q,
    output logic                   rvalid_q
);

    localparam int CB = cnt_base(NCH);

    reg_kind_e kind;
    bus_op_t   op;
    logic [CW-1:0] rmux;

    always_comb begin
        kind  = kind_of(int'(bus_addr), NCH);
        op.wr = bus_wr;
        op.rd = bus_rd;
    end

    // strobes live for the write cycle only
    always_comb begin
        frc_vec = (op.wr && kind == K_FRC) ? bus_wdata[NCH-1:0] : '0;
        clr_vec = (op.wr && kind == K_FLG) ? bus_wdata[NCH-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            ie_q <= '0;
        end else if (op.wr) begin
            if (kind == K_EN) en_q <= bus_wdata[NCH-1:0];
            if (kind == K_IE) ie_q <= bus_wdata[NCH-1:0];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ld
        always_ff @(posedge clk) begin
            if (rst)
                ld_vec[c] <= '0;
            else if (op.wr && bus_addr == AW'(LD_BASE + c))
                ld_vec[c] <= bus_wdata;
        end
    end

    always_comb begin
        rmux = '0;
        case (kind)
            K_EN:  rmux = CW'(en_q);
            K_IE:  rmux = CW'(ie_q);
            K_FLG: rmux = CW'(flag_vec);
            K_LD: begin
                for (int c = 0; c < NCH; c++)
                    if (bus_addr == AW'(LD_BASE + c)) rmux = ld_vec[c];
            end
            K_CNT: begin
                for (int c = 0; c < NCH; c++)
                    if (bus_addr == AW'(CB + c)) rmux = cnt_vec[c];
            end
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= op.rd;
            if (op.rd) rdata_q <= rmux;
        end
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int NCH = DEF_NCH,
    parameter int CW  = DEF_CW,
    parameter int AW  = addr_width(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic           bus_rvalid,
    output logic [NCH-1:0] irq
);

    logic [NCH-1:0]         en_q;
    logic [NCH-1:0]         ie_q;
    logic [NCH-1:0]         frc_vec;
    logic [NCH-1:0]         clr_vec;
    logic [NCH-1:0]         flag_vec;
    logic [NCH-1:0][CW-1:0] ld_vec;
    logic [NCH-1:0][CW-1:0] cnt_vec;

    pit_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cnt_vec  (cnt_vec),
        .flag_vec (flag_vec),
        .en_q     (en_q),
        .ie_q     (ie_q),
        .ld_vec   (ld_vec),
        .frc_vec  (frc_vec),
        .clr_vec  (clr_vec),
        .rdata_q  (bus_rdata),
        .rvalid_q (bus_rvalid)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pit_chan #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .en    (en_q[c]),
            .frc   (frc_vec[c]),
            .clr   (clr_vec[c]),
            .ld    (ld_vec[c]),
            .cnt_q (cnt_vec[c]),
            .flag_q(flag_vec[c])
        );
    end

    assign irq = flag_vec & ie_q;

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         en,
    input logic [NCH-1:0]         ie,
    input logic [NCH-1:0]         frc,
    input logic [NCH-1:0]         clr,
    input logic [NCH-1:0]         flag,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0][CW-1:0] ld
);

    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R2
        dec_chk: assert property (@(posedge clk) disable iff (rst)
            en[c] && tick && !frc[c] && cnt[c] != '0 |=> cnt[c] == $past(cnt[c]) - CW'(1));
        // R2
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(en[c] && tick) && !frc[c] |=> $stable(cnt[c]));
        // R3
        reload_chk: assert property (@(posedge clk) disable iff (rst)
            en[c] && tick && !frc[c] && cnt[c] == '0 |=> cnt[c] == $past(ld[c]) && flag[c]);
        // R5
        force_chk: assert property (@(posedge clk) disable iff (rst)
            frc[c] |=> cnt[c] == $past(ld[c]));
        // R7
        flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
            flag[c] && !clr[c] |=> flag[c]);
        // R8
        irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
            irq[c] |-> ie[c] && flag[c]);
    end

endmodule

bind pit_timer pit_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .irq (irq),
    .en  (en_q),
    .ie  (ie_q),
    .frc (frc_vec),
    .clr (clr_vec),
    .flag(flag_vec),
    .cnt (cnt_vec),
    .ld  (ld_vec)
);

// File: tb/pit_timer_test.sv
module pit_timer_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic [3:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [15:0] exp;
        logic [3:0]  addr;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    pit_timer uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .irq       (irq)
    );

    always #(PERIOD / 2) clk = ~clk;

    // monitor: pop expected read results as they appear
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read data: got %h expected none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr %0d: got %h expected %h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input bit t = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = t;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [15:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.exp = e; it.addr = a; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk_irq(input logic [3:0] e, input string tag);
        @(negedge clk);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_exp(4'd8, 16'h0000, "R1");
        rd_exp(4'd2, 16'h0000, "R1");
        rd_exp(4'd4, 16'h0000, "R1");
        rd_exp(4'd0, 16'h0000, "R1");
        chk_irq(4'b0000, "R1");

        // R10 load readback, R4 count untouched
        wr(4'd4, 16'd5);
        rd_exp(4'd4, 16'd5, "R10");
        rd_exp(4'd8, 16'd0, "R4");

        // R3 terminal count at zero reloads and flags
        wr(4'd0, 16'h0001);
        ticks(1);
        rd_exp(4'd8, 16'd5, "R3");
        rd_exp(4'd2, 16'h0001, "R3");

        // R8 gating by interrupt enable
        chk_irq(4'b0000, "R8");
        wr(4'd1, 16'h0001);
        chk_irq(4'b0001, "R8");

        // R7 zero bits keep, one bits clear
        wr(4'd2, 16'h0000);
        rd_exp(4'd2, 16'h0001, "R7");
        wr(4'd2, 16'h0001);
        rd_exp(4'd2, 16'h0000, "R7");
        chk_irq(4'b0000, "R8");

        // R2 decrement and hold
        ticks(3);
        rd_exp(4'd8, 16'd2, "R2");
        repeat (3) @(negedge clk);
        rd_exp(4'd8, 16'd2, "R2");

        // R4 new load used only at terminal count
        wr(4'd4, 16'd9);
        rd_exp(4'd8, 16'd2, "R4");
        ticks(3);
        rd_exp(4'd8, 16'd9, "R4");
        rd_exp(4'd2, 16'h0001, "R3");

        // R6 count write ignored
        wr(4'd8, 16'h1234);
        rd_exp(4'd8, 16'd9, "R6");

        // R5 force load, no flag
        wr(4'd2, 16'h0001);
        wr(4'd4, 16'h00AB);
        wr(4'd3, 16'h0001);
        rd_exp(4'd8, 16'h00AB, "R5");
        rd_exp(4'd2, 16'h0000, "R5");

        // R5 force beats same-cycle tick
        wr(4'd3, 16'h0001, 1'b1);
        rd_exp(4'd8, 16'h00AB, "R5");

        // R2 disabled channel holds under ticks
        wr(4'd0, 16'h0000);
        ticks(4);
        rd_exp(4'd8, 16'h00AB, "R2");

        // R7 time-out beats same-cycle clear
        wr(4'd4, 16'd0);
        wr(4'd3, 16'h0001);
        wr(4'd0, 16'h0001);
        ticks(1);
        wr(4'd2, 16'h0001, 1'b1);
        rd_exp(4'd2, 16'h0001, "R7");
        wr(4'd2, 16'h0001);
        rd_exp(4'd2, 16'h0000, "R7");

        // R9 independent channels
        wr(4'd0, 16'h0004);
        wr(4'd6, 16'd3);
        ticks(2);
        rd_exp(4'd10, 16'd2, "R9");
        rd_exp(4'd8, 16'd0, "R9");
        rd_exp(4'd2, 16'h0004, "R9");
        chk_irq(4'b0000, "R8");
        wr(4'd1, 16'h0004);
        chk_irq(4'b0100, "R8");
        rd_exp(4'd6, 16'd3, "R10");
        rd_exp(4'd4, 16'd0, "R10");

        repeat (3) @(negedge clk);
        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule